// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with a small 16-bit register interface. It runs from a slow periodic tick, a one-cycle pulse at 2 Hz that is derived from a 32.768 kHz reference. Software sets an 8-bit timeout field and starts the counter. It must then feed the counter by writing an ordered pair of key words to the service register before the count runs out. If the count runs out, the block raises its reset output for one tick period and records that the reset was caused by a timeout.

Software can also request a reset directly through an active-low bit in the control register. A low-power input, together with a suspend bit, can freeze the count. The enable bit and the suspend bit can only be set. Once the counter is running, nothing short of a reset stops it.

The block has two reset inputs. Power-on reset clears everything. The system reset, which also follows a watchdog-induced reset, clears everything except the reset-cause flag.

Top module: `wdog_keyed`

## Requirements
- R1: After power-on reset, the control register at offset 0x0 reads 0x0010, the status register at offset 0x4 reads 0x0000 and `wdog_rst` is low. Offsets 0x2, 0x6 and 0x8 always read 0x0000.
- R2: The control register fields are as follows. Bits 15:8 are the timeout field N. Bit 4 is the software reset request, active low, and always reads 1. Bit 3 is the reset enable. Bit 2 is the counter enable. Bit 0 is the low-power suspend bit. Bits 3 and 15:8 read back as written.
- R3: The counter enable can only be set. A write of 0 to bit 2 leaves it reading 1, and the counter keeps running.
- R4: The suspend bit can only be set. Writing 0 to it before it has been set leaves it at 0. After it has been set, it keeps reading 1.
- R5: When the counter is enabled with timeout field N and reset enable set, and no service happens, `wdog_rst` rises at the (N+1)th tick after the enabling write. That is (N+1)/2 seconds at 2 Hz. It falls again at the next tick.
- R6: The counter is reloaded to N only by writing 0x5555 and then 0xAAAA to the service register at offset 0x2. A lone 0xAAAA is ignored. Any other value written to the service register after 0x5555 cancels the pair.
- R7: The timeout field can be rewritten while the counter runs. The counter in progress is not changed, and the new value applies from the next reload.
- R8: Writing the control register with bit 4 at 0 raises `wdog_rst` after that write, whatever the counter state. The output stays high until the next tick, and the status flag is cleared.
- R9: While the suspend bit is set and `lowpwr` is high, ticks do not change the count. With the suspend bit clear, `lowpwr` has no effect.
- R10: Bit 1 of the status register reads 1 after a timeout reset. The flag survives `sys_rst_n` and is cleared by `por_n`.
- R11: If the completing 0xAAAA write falls in the same cycle as the tick that would expire the counter, the service wins. No reset occurs, and a full N+1 tick interval restarts.
- R12: With reset enable at 0, expiry does not raise `wdog_rst` and does not set the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low; keeps the status flag |
| tick | input | 1 | One-cycle count pulse (2 Hz) |
| lowpwr | input | 1 | Low-power mode indication |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| wdog_rst | output | 1 | Reset request output |

## Verification
The completion of a service pair can land in the same cycle as the tick that would expire the counter. The bench provokes this by counting the counter down to zero, writing the first key, and then presenting the second key in the same cycle as a tick. The result is correct if `wdog_rst` stays low at that point and the next rise comes exactly N+1 ticks later, which shows that the reload took priority over expiry.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter logic [15:0] KEY_A = 16'h5555,
  parameter logic [15:0] KEY_B = 16'hAAAA
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        tick,
  input  logic        lowpwr,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        wdog_rst
);
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_SVC  = 4'h2;
  localparam logic [3:0] A_STAT = 4'h4;

  logic [7:0] tmo, cnt;
  logic en, rst_en, susp, armed, tout, rst_q;

  wire rst_n   = por_n & sys_rst_n;
  wire ctrl_wr = we && (addr == A_CTRL);
  wire svc_wr  = we && (addr == A_SVC);
  wire svc_ok  = svc_wr && armed && (wdata == KEY_B);
  wire en_load = ctrl_wr && wdata[2] && !en;
  wire run     = en && !(susp && lowpwr);
  wire expire  = run && tick && (cnt == 8'd0) && !svc_ok;
  wire sw_req  = ctrl_wr && !wdata[4];
  wire hit     = expire && rst_en;

  assign wdog_rst = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo <= '0; rst_en <= 1'b0; en <= 1'b0; susp <= 1'b0;
    end else if (ctrl_wr) begin
      tmo    <= wdata[15:8];
      rst_en <= wdata[3];
      en     <= en | wdata[2];
      susp   <= susp | wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (svc_wr) armed <= (wdata == KEY_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (en_load) cnt <= wdata[15:8];
    else if (svc_ok) cnt <= tmo;
    else if (run && tick) cnt <= (cnt == 8'd0) ? tmo : cnt - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else if (hit || sw_req) rst_q <= 1'b1;
    else if (tick) rst_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) tout <= 1'b0;
    else if (hit) tout <= 1'b1;
    else if (sw_req) tout <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {tmo, 3'b000, 1'b1, rst_en, en, 1'b0, susp};
      A_STAT:  rdata = {14'd0, tout, 1'b0};
      default: rdata = 16'h0000;
    endcase
  end
endmodule

module wdog_keyed_chk (
  input logic       clk,
  input logic       por_n,
  input logic       sys_rst_n,
  input logic       lowpwr,
  input logic       we,
  input logic [3:0] addr,
  input logic       wdog_rst,
  input logic       en,
  input logic       susp,
  input logic       rst_en,
  input logic       tick,
  input logic [7:0] cnt,
  input logic       tout
);
  wire any_rst = !por_n || !sys_rst_n;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (any_rst)
    en |=> en); // R3
  AST_SUSP_STICKY: assert property (@(posedge clk) disable iff (any_rst)
    susp |=> susp); // R4
  AST_RST_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (any_rst)
    $fell(wdog_rst) |-> $past(tick)); // R8
  AST_LP_HOLD: assert property (@(posedge clk) disable iff (any_rst)
    (en && susp && lowpwr && !(we && addr == 4'h2)) |=> $stable(cnt)); // R9
  AST_TOUT_WITH_RST: assert property (@(posedge clk) disable iff (any_rst)
    $rose(tout) |-> wdog_rst); // R10
  AST_NO_RST_DISABLED: assert property (@(posedge clk) disable iff (any_rst)
    (!rst_en && !(we && addr == 4'h0)) |=> !$rose(wdog_rst)); // R12
endmodule

bind wdog_keyed wdog_keyed_chk u_chk (.*);

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, por_n = 1'b0, sys_rst_n = 1'b1, tick = 1'b0, lowpwr = 1'b0, we = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [15:0] wdata = 16'h0, rdata;
  logic wdog_rst;
  int n_chk = 0, n_err = 0;
  int idx;
  logic [15:0] rv;

  wdog_keyed u_dut (.clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick),
    .lowpwr(lowpwr), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .wdog_rst(wdog_rst));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk) por_n = 1'b0; lowpwr = 1'b0;
    @(negedge clk) por_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk) we = 1'b1; addr = a; wdata = d;
    @(negedge clk) we = 1'b0;
  endtask

  task automatic wr_tick(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk) we = 1'b1; addr = a; wdata = d; tick = 1'b1;
    @(negedge clk) we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk) addr = a;
    #1 d = rdata;
  endtask

  task automatic tick1();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic fire_at(input int lim, output int k_out);
    k_out = 0;
    for (int k = 1; k <= lim; k++) begin
      tick1();
      if (wdog_rst) begin k_out = k; break; end
    end
  endtask

  task automatic start(input logic [7:0] n);
    por();
    wr(4'h0, {n, 8'h1C});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    por();
    // R1 reset state and unused offsets
    rd(4'h0, rv); chk("R1 ctrl", rv, 16'h0010);
    rd(4'h4, rv); chk("R1 stat", rv, 0);
    chk("R1 rst", wdog_rst, 0);
    rd(4'h2, rv); chk("R1 off2", rv, 0);
    rd(4'h8, rv); chk("R1 off8", rv, 0);

    // R2 field placement; R4 suspend not set by a 0 write
    wr(4'h0, 16'hA518); rd(4'h0, rv); chk("R2 ctrl readback", rv, 16'hA518);
    // R4 set once then locked
    wr(4'h0, 16'h0011); rd(4'h0, rv); chk("R4 susp set", rv & 16'h1, 1);
    wr(4'h0, 16'h0010); rd(4'h0, rv); chk("R4 susp locked", rv & 16'h1, 1);

    // R5 sweep of timeout values
    for (int n = 0; n < 16; n++) begin
      start(8'(n)); fire_at(300, idx); chk("R5 expiry tick", idx, n + 1);
    end
    start(8'd255); fire_at(300, idx); chk("R5 expiry tick 255", idx, 256);
    tick1(); chk("R5 pulse ends", wdog_rst, 0);

    // R10 cause flag, sys reset keeps it, por clears it
    rd(4'h4, rv); chk("R10 stat set", rv, 16'h0002);
    @(negedge clk) sys_rst_n = 1'b0; @(negedge clk) sys_rst_n = 1'b1;
    rd(4'h4, rv); chk("R10 stat kept", rv, 16'h0002);
    rd(4'h0, rv); chk("R10 ctrl reset", rv, 16'h0010);
    por(); rd(4'h4, rv); chk("R10 stat cleared", rv, 0);

    // R3 enable cannot be cleared
    start(8'd3); wr(4'h0, 16'h0318); rd(4'h0, rv); chk("R3 en sticky", rv & 16'h4, 4);
    fire_at(20, idx); chk("R3 still runs", idx, 4);

    // R6 valid pair reloads
    start(8'd4); repeat (3) tick1();
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    fire_at(20, idx); chk("R6 reload", idx, 5);
    // R6 lone second key ignored
    start(8'd4); repeat (3) tick1();
    wr(4'h2, 16'hAAAA); fire_at(20, idx); chk("R6 lone key", idx, 2);
    // R6 interrupted pair
    start(8'd4); repeat (3) tick1();
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    fire_at(20, idx); chk("R6 broken pair", idx, 2);

    // R7 new timeout only at next reload
    start(8'd2); wr(4'h0, 16'h061C); fire_at(20, idx); chk("R7 old count", idx, 3);
    start(8'd2); wr(4'h0, 16'h061C); tick1();
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA); fire_at(20, idx); chk("R7 new count", idx, 7);

    // R11 service completion on the expiring tick
    start(8'd3); repeat (3) tick1();
    wr(4'h2, 16'h5555); wr_tick(4'h2, 16'hAAAA);
    chk("R11 no reset", wdog_rst, 0);
    fire_at(20, idx); chk("R11 full interval", idx, 4);

    // R8 software reset while idle, and clearing the cause flag
    por(); wr(4'h0, 16'h0000); chk("R8 sw rst high", wdog_rst, 1);
    tick1(); chk("R8 sw rst low", wdog_rst, 0);
    start(8'd0); fire_at(5, idx); tick1();
    wr(4'h0, 16'h0000); rd(4'h4, rv); chk("R8 stat cleared", rv, 0);

    // R9 low-power hold with suspend set
    por(); wr(4'h0, 16'h021D); tick1();
    lowpwr = 1'b1; fire_at(10, idx); chk("R9 held", idx, 0);
    lowpwr = 1'b0; fire_at(20, idx); chk("R9 resumes", idx, 2);
    // R9 lowpwr without suspend has no effect
    start(8'd2); lowpwr = 1'b1; fire_at(20, idx); chk("R9 no suspend", idx, 3);
    lowpwr = 1'b0;

    // R12 reset enable clear
    por(); wr(4'h0, 16'h0114); fire_at(8, idx); chk("R12 no reset", idx, 0);
    rd(4'h4, rv); chk("R12 stat", rv, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule